// File: doc/BRIEF.md
# Cyclic Trace Recorder

The recorder captures three kinds of activity from a processor core and writes each as one tagged word into a reserved window of a local RAM. The first kind is a program-flow discontinuity, which carries the new fetch address after a jump or call. The second is a data access, which carries the address and whether the access was a read or a write. The third is a change on any of a small group of monitored event lines, which carries the new line levels and the value of a free-running 32-bit cycle counter. Sequential fetches are never reported. Only event words carry the counter value.

The window occupies the highest addresses of the RAM. Its length is picked by a size code, and code 0 turns recording off. In single-shot mode the recorder stops once every slot has been written. In continuous mode the pointer returns to the first slot and keeps writing until tracing is disabled. A processor halt pauses recording without losing the pointer. At most one word is written per cycle. Data words go out in the cycle they arrive. Event and program words wait in one-deep holding registers, and the event word drains before the program word.

The control state machine has four states: IDLE, RECORD, PAUSED and FULL. Its transitions are:
- start (IDLE to RECORD, when enabled, not halted and the size code is valid; this clears the pointer and the flags)
- pause (RECORD to PAUSED, on halt)
- resume (PAUSED to RECORD, when the halt drops)
- fill (RECORD to FULL, when the last slot is written in single-shot mode)
- disable (any state to IDLE, when the enable drops)

Top module: `trace_recorder`

## Requirements
- R1: After reset, ram_we, wr_ptr, wrapped, stopped and overflow are all 0.
- R2: Size codes 1, 2, 3 and 4 select a window of 16, 32, 64 or 128 words (UNIT_WORDS doubled per step) ending at the last RAM word. The first write after start goes to address 1024 minus the window length, and later writes go to consecutive addresses.
- R3: A data access seen while recording is written on the next clock edge. The word has tag 2'b10 in bits 39:38, the write flag (1 = write) in bit 24 and the access address in bits 23:0.
- R4: A branch target seen while recording is held one cycle and then written with tag 2'b01 in bits 39:38 and the target in bits 23:0. Nothing is written in the cycle the branch arrives.
- R5: When records compete for the write port, a data word wins over a held event word, and a held event word wins over a held program word. Losers are written in later cycles.
- R6: Any change of the event lines produces one word with tag 2'b11, the new levels in bits 35:32 and the timestamp in bits 31:0. Unchanged lines produce no word.
- R7: Event timestamps come from a counter that steps once per clock, so two event words differ in timestamp by exactly the number of cycles between the two changes.
- R8: In single-shot mode the recorder enters FULL once the last window slot is written. It raises stopped, writes nothing more and leaves wrapped at 0.
- R9: In continuous mode the write after the last slot goes to the window's first address, and wrapped becomes 1 and stays 1.
- R10: Size code 0 and codes 5 to 7 keep the recorder in IDLE, and no RAM write is issued.
- R11: A halt pauses recording with wr_ptr kept, and recording continues from the next slot one cycle after the halt drops. Dropping the enable stops all writes, and the next start clears wr_ptr and all flags.
- R12: A branch that arrives while the program holding register is still full and not draining sets the sticky overflow flag. The newer target replaces the held one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trc_en | input | 1 | Tracing enable |
| cpu_halt | input | 1 | Core halted; pauses recording |
| cont_mode | input | 1 | 1 = continuous ring, 0 = single-shot |
| size_sel | input | 3 | Window size code (0 = off, 1..4 valid) |
| br_valid | input | 1 | Discontinuity taken this cycle |
| br_target | input | 24 | New fetch address |
| da_valid | input | 1 | Data access this cycle |
| da_write | input | 1 | 1 = write access, 0 = read |
| da_addr | input | 24 | Data access address |
| ev_in | input | 4 | Monitored event lines |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 10 | RAM word address |
| ram_wdata | output | 40 | Record word |
| wr_ptr | output | 10 | Next slot offset inside the window |
| wrapped | output | 1 | Sticky: ring has overwritten old words |
| stopped | output | 1 | Single-shot window is full |
| overflow | output | 1 | Sticky: a held record was replaced |

## Verification
The bench sends a data access, a branch and an event change in one cycle and checks that the three words come out in the order data, event, program. An arbiter with the wrong priority would write them in the wrong order, or lose the program word. It fills a 16-word window in both modes to probe the last slot. An off-by-one there would write outside the window, stop one word early or late, or set wrapped in single-shot mode. It makes a branch collide with a branch that is still held behind a data word, which shows whether overflow is raised and whether the newer target is kept. It also spaces two event changes five cycles apart to expose a counter that is latched at the wrong edge. Finally it checks that a halt, a disable and an invalid size code each suppress writes as required.

// File: rtl/trace_pkg.sv
package trace_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RECORD = 2'd1,
        ST_PAUSED = 2'd2,
        ST_FULL   = 2'd3
    } trc_state_e;

    typedef enum logic [1:0] {
        TAG_NONE  = 2'b00,
        TAG_PROG  = 2'b01,
        TAG_DATA  = 2'b10,
        TAG_EVENT = 2'b11
    } rec_tag_e;

    localparam int TS_W = 32;

endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl
    import trace_pkg::*;
#(
    parameter int SIZE_W   = 3,
    parameter int MAX_CODE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trc_en,
    input  logic              cpu_halt,
    input  logic              cont_mode,
    input  logic [SIZE_W-1:0] size_sel,
    input  logic              last_write,
    output trc_state_e        state_o,
    output logic              rec_on,
    output logic              start,
    output logic              active,
    output logic              stopped,
    output logic [SIZE_W-1:0] cfg_size,
    output logic              cfg_cont
);

    trc_state_e state_q, state_d;
    logic       size_ok;

    assign size_ok = (size_sel != '0) && (size_sel <= SIZE_W'(MAX_CODE));

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trc_en && !cpu_halt && size_ok) state_d = ST_RECORD;   // start
            end
            ST_RECORD: begin
                if (!trc_en)                       state_d = ST_IDLE;      // disable
                else if (cpu_halt)                 state_d = ST_PAUSED;    // pause
                else if (last_write && !cfg_cont)  state_d = ST_FULL;      // fill
            end
            ST_PAUSED: begin
                if (!trc_en)                       state_d = ST_IDLE;      // disable
                else if (!cpu_halt)                state_d = ST_RECORD;    // resume
            end
            ST_FULL: begin
                if (!trc_en)                       state_d = ST_IDLE;      // disable
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        rec_on  = (state_q == ST_RECORD) && trc_en && !cpu_halt;
        start   = (state_q == ST_IDLE) && (state_d == ST_RECORD);
        active  = (state_q != ST_IDLE);
        stopped = (state_q == ST_FULL);
        state_o = state_q;
    end

    // configuration is only sampled while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_size <= '0;
            cfg_cont <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            cfg_size <= size_sel;
            cfg_cont <= cont_mode;
        end
    end

    assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL && trc_en) |=> (state_q == ST_FULL));

    assert_bad_size_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !size_ok) |=> (state_q == ST_IDLE));

    assert_single_shot_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_on && last_write && !cfg_cont) |=> stopped);

endmodule

// File: rtl/trace_capture.sv
module trace_capture
    import trace_pkg::*;
#(
    parameter int PC_W = 24,
    parameter int N_EV = 4,
    parameter int DW   = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rec_on,
    input  logic            start,
    input  logic            br_valid,
    input  logic [PC_W-1:0] br_target,
    input  logic            da_valid,
    input  logic            da_write,
    input  logic [PC_W-1:0] da_addr,
    input  logic [N_EV-1:0] ev_in,
    output logic            issue,
    output logic [DW-1:0]   rec_word,
    output logic            overflow
);

    logic [TS_W-1:0] ts_q;
    logic [N_EV-1:0] ev_prev;
    logic            ev_chg;
    logic            ev_pend;
    logic [N_EV-1:0] ev_lvl;
    logic [TS_W-1:0] ev_ts;
    logic            pc_pend;
    logic [PC_W-1:0] pc_hold;
    logic            sel_data, sel_ev, sel_pc;

    assign ev_chg = (ev_in != ev_prev);

    // free-running stamp and edge detector run regardless of state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_q    <= '0;
            ev_prev <= '0;
        end else begin
            ts_q    <= ts_q + 1'b1;
            ev_prev <= ev_in;
        end
    end

    // fixed priority: data, then held event, then held program word
    always_comb begin
        sel_data = rec_on && da_valid;
        sel_ev   = rec_on && !da_valid && ev_pend;
        sel_pc   = rec_on && !da_valid && !ev_pend && pc_pend;
        issue    = sel_data || sel_ev || sel_pc;
    end

    always_comb begin
        rec_word = '0;
        if (sel_data) begin
            rec_word[DW-1 -: 2]    = TAG_DATA;
            rec_word[PC_W]         = da_write;
            rec_word[PC_W-1:0]     = da_addr;
        end else if (sel_ev) begin
            rec_word[DW-1 -: 2]    = TAG_EVENT;
            rec_word[TS_W +: N_EV] = ev_lvl;
            rec_word[TS_W-1:0]     = ev_ts;
        end else if (sel_pc) begin
            rec_word[DW-1 -: 2]    = TAG_PROG;
            rec_word[PC_W-1:0]     = pc_hold;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_pend  <= 1'b0;
            ev_lvl   <= '0;
            ev_ts    <= '0;
            pc_pend  <= 1'b0;
            pc_hold  <= '0;
            overflow <= 1'b0;
        end else if (start) begin
            ev_pend  <= 1'b0;
            pc_pend  <= 1'b0;
            overflow <= 1'b0;
        end else begin
            if (sel_ev) ev_pend <= 1'b0;
            if (rec_on && ev_chg) begin
                ev_pend <= 1'b1;
                ev_lvl  <= ev_in;
                ev_ts   <= ts_q;
                if (ev_pend && !sel_ev) overflow <= 1'b1;
            end
            if (sel_pc) pc_pend <= 1'b0;
            if (rec_on && br_valid) begin
                pc_pend <= 1'b1;
                pc_hold <= br_target;
                if (pc_pend && !sel_pc) overflow <= 1'b1;
            end
        end
    end

    assert_ts_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ts_q == $past(ts_q) + 1'b1));

    assert_ovf_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !start) |=> overflow);

    assert_one_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_data, sel_ev, sel_pc}));

endmodule

// File: rtl/trace_ring.sv
module trace_ring
    import trace_pkg::*;
#(
    parameter int RAM_AW     = 10,
    parameter int UNIT_WORDS = 16,
    parameter int SIZE_W     = 3,
    parameter int MAX_CODE   = 4,
    parameter int DW         = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              active,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              cfg_cont,
    input  logic              issue,
    input  logic [DW-1:0]     rec_word,
    output logic              last_write,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DW-1:0]     ram_wdata,
    output logic [RAM_AW-1:0] wr_ptr,
    output logic              wrapped
);

    localparam int          WW    = RAM_AW + 1;
    localparam logic [WW-1:0] DEPTH = {1'b1, {RAM_AW{1'b0}}};

    logic [WW-1:0] words;
    logic [WW-1:0] base;

    always_comb begin
        if (cfg_size != '0 && cfg_size <= SIZE_W'(MAX_CODE))
            words = WW'(UNIT_WORDS) << (cfg_size - SIZE_W'(1));
        else
            words = '0;
        base       = DEPTH - words;
        last_write = issue && ({1'b0, wr_ptr} == words - WW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            wrapped <= 1'b0;
        end else if (start) begin
            wr_ptr  <= '0;
            wrapped <= 1'b0;
        end else if (issue) begin
            if (last_write) begin
                wr_ptr <= '0;
                if (cfg_cont) wrapped <= 1'b1;
            end else begin
                wr_ptr <= wr_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we <= issue;
            if (issue) begin
                ram_addr  <= base[RAM_AW-1:0] + wr_ptr;
                ram_wdata <= rec_word;
            end
        end
    end

    assert_ptr_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ({1'b0, wr_ptr} < words));

    assert_addr_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && active) |-> ({1'b0, ram_addr} >= base));

    assert_wrap_cont_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrapped) |-> cfg_cont);

endmodule

// File: rtl/trace_recorder.sv
module trace_recorder
    import trace_pkg::*;
#(
    parameter int PC_W       = 24,
    parameter int N_EV       = 4,
    parameter int DW         = 40,
    parameter int RAM_AW     = 10,
    parameter int UNIT_WORDS = 16,
    parameter int SIZE_W     = 3,
    parameter int MAX_CODE   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trc_en,
    input  logic              cpu_halt,
    input  logic              cont_mode,
    input  logic [SIZE_W-1:0] size_sel,
    input  logic              br_valid,
    input  logic [PC_W-1:0]   br_target,
    input  logic              da_valid,
    input  logic              da_write,
    input  logic [PC_W-1:0]   da_addr,
    input  logic [N_EV-1:0]   ev_in,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DW-1:0]     ram_wdata,
    output logic [RAM_AW-1:0] wr_ptr,
    output logic              wrapped,
    output logic              stopped,
    output logic              overflow
);

    trc_state_e        state;
    logic              rec_on, start, active, last_write, issue;
    logic [SIZE_W-1:0] cfg_size;
    logic              cfg_cont;
    logic [DW-1:0]     rec_word;

    trace_ctrl #(.SIZE_W(SIZE_W), .MAX_CODE(MAX_CODE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .trc_en(trc_en), .cpu_halt(cpu_halt),
        .cont_mode(cont_mode), .size_sel(size_sel), .last_write(last_write),
        .state_o(state), .rec_on(rec_on), .start(start), .active(active),
        .stopped(stopped), .cfg_size(cfg_size), .cfg_cont(cfg_cont)
    );

    trace_capture #(.PC_W(PC_W), .N_EV(N_EV), .DW(DW)) u_capture (
        .clk(clk), .rst_n(rst_n), .rec_on(rec_on), .start(start),
        .br_valid(br_valid), .br_target(br_target),
        .da_valid(da_valid), .da_write(da_write), .da_addr(da_addr),
        .ev_in(ev_in), .issue(issue), .rec_word(rec_word), .overflow(overflow)
    );

    trace_ring #(.RAM_AW(RAM_AW), .UNIT_WORDS(UNIT_WORDS), .SIZE_W(SIZE_W),
                 .MAX_CODE(MAX_CODE), .DW(DW)) u_ring (
        .clk(clk), .rst_n(rst_n), .start(start), .active(active),
        .cfg_size(cfg_size), .cfg_cont(cfg_cont), .issue(issue),
        .rec_word(rec_word), .last_write(last_write), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .wr_ptr(wr_ptr),
        .wrapped(wrapped)
    );

    assert_data_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_on && da_valid) |=> (ram_we && ram_wdata[DW-1 -: 2] == TAG_DATA));

    assert_write_only_recording_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ($past(state) == ST_RECORD));

endmodule

// File: tb/test_trace_recorder.sv
`timescale 1ns/1ps
module test_trace_recorder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        trc_en, cpu_halt, cont_mode;
    logic [2:0]  size_sel;
    logic        br_valid, da_valid, da_write;
    logic [23:0] br_target, da_addr;
    logic [3:0]  ev_in;
    logic        ram_we, wrapped, stopped, overflow;
    logic [9:0]  ram_addr, wr_ptr;
    logic [39:0] ram_wdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    trace_recorder i_trace_recorder (
        .clk(clk), .rst_n(rst_n), .trc_en(trc_en), .cpu_halt(cpu_halt),
        .cont_mode(cont_mode), .size_sel(size_sel), .br_valid(br_valid),
        .br_target(br_target), .da_valid(da_valid), .da_write(da_write),
        .da_addr(da_addr), .ev_in(ev_in), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .wr_ptr(wr_ptr), .wrapped(wrapped),
        .stopped(stopped), .overflow(overflow)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic restart(input logic [2:0] sz, input logic cont);
        trc_en = 1'b0;
        tick();
        size_sel  = sz;
        cont_mode = cont;
        trc_en    = 1'b1;
        tick();
    endtask

    task automatic put_data(input logic [23:0] a, input logic w);
        da_valid = 1'b1; da_addr = a; da_write = w;
        tick();
        da_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 ram_we",   64'(ram_we),   0);
        check("R1 wr_ptr",   64'(wr_ptr),   0);
        check("R1 wrapped",  64'(wrapped),  0);
        check("R1 stopped",  64'(stopped),  0);
        check("R1 overflow", 64'(overflow), 0);
    endtask

    task automatic t_sizes();
        for (int sz = 1; sz <= 4; sz++) begin
            restart(3'(sz), 1'b1);
            put_data(24'h00A000 + 24'(sz), sz[0]);
            check("R2 first address", 64'(ram_addr), 64'(1024 - (16 << (sz - 1))));
            check("R3 data tag",      64'(ram_wdata[39:38]), 2);
            check("R3 write flag",    64'(ram_wdata[24]), 64'(sz[0]));
            check("R3 address field", 64'(ram_wdata[23:0]), 64'(24'h00A000 + sz));
            put_data(24'h000055, 1'b0);
            check("R2 next address",  64'(ram_addr), 64'(1025 - (16 << (sz - 1))));
        end
    endtask

    task automatic t_single();
        restart(3'd1, 1'b0);
        for (int i = 0; i < 16; i++) begin
            put_data(24'(i), 1'b1);
            check("R2 fill address", 64'(ram_addr), 64'(1008 + i));
        end
        check("R8 stopped",      64'(stopped), 1);
        check("R8 wrapped clear", 64'(wrapped), 0);
        put_data(24'h0000FF, 1'b1);
        check("R8 no write when full", 64'(ram_we), 0);
    endtask

    task automatic t_cont();
        restart(3'd1, 1'b1);
        for (int i = 0; i < 17; i++) put_data(24'(i), 1'b0);
        check("R9 wrap address", 64'(ram_addr), 1008);
        check("R9 wrapped",      64'(wrapped),  1);
        check("R9 pointer",      64'(wr_ptr),   1);
        check("R9 still writing", 64'(stopped), 0);
    endtask

    task automatic t_prio();
        restart(3'd4, 1'b1);
        da_valid = 1'b1; da_addr = 24'h123456; da_write = 1'b0;
        br_valid = 1'b1; br_target = 24'hABCDEF;
        ev_in    = ev_in ^ 4'b0101;
        tick();
        da_valid = 1'b0; br_valid = 1'b0;
        check("R5 data first we",  64'(ram_we), 1);
        check("R5 data first tag", 64'(ram_wdata[39:38]), 2);
        check("R3 read flag",      64'(ram_wdata[24]), 0);
        tick();
        check("R5 event second tag", 64'(ram_wdata[39:38]), 3);
        check("R6 event levels",     64'(ram_wdata[35:32]), 64'(ev_in));
        tick();
        check("R5 program last tag", 64'(ram_wdata[39:38]), 1);
        check("R4 program target",   64'(ram_wdata[23:0]), 64'h0ABCDEF);
        tick();
        check("R6 no word without change", 64'(ram_we), 0);
    endtask

    task automatic t_ts();
        logic [31:0] ts1;
        restart(3'd4, 1'b1);
        ev_in = ev_in ^ 4'b0001;
        tick();
        tick();
        check("R6 event tag", 64'(ram_wdata[39:38]), 3);
        ts1 = ram_wdata[31:0];
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R6 quiet lines", 64'(ram_we), 0);
        end
        ev_in = ev_in ^ 4'b0010;
        tick();
        tick();
        check("R6 second event", 64'(ram_we), 1);
        check("R7 stamp distance", 64'(ram_wdata[31:0] - ts1), 5);
    endtask

    task automatic t_branch();
        restart(3'd4, 1'b1);
        br_valid = 1'b1; br_target = 24'h00F00D;
        tick();
        br_valid = 1'b0;
        check("R4 not written on arrival", 64'(ram_we), 0);
        tick();
        check("R4 written next cycle", 64'(ram_we), 1);
        check("R4 tag",    64'(ram_wdata[39:38]), 1);
        check("R4 target", 64'(ram_wdata[23:0]), 64'h000F00D);
    endtask

    task automatic t_ovf();
        restart(3'd4, 1'b1);
        check("R12 clear at start", 64'(overflow), 0);
        br_valid = 1'b1; br_target = 24'h000111;
        tick();
        br_target = 24'h000222;
        da_valid = 1'b1; da_addr = 24'h000333; da_write = 1'b1;
        tick();
        br_valid = 1'b0; da_valid = 1'b0;
        check("R12 data written", 64'(ram_wdata[39:38]), 2);
        check("R12 overflow set", 64'(overflow), 1);
        tick();
        check("R12 newest target kept", 64'(ram_wdata[23:0]), 64'h0000222);
        tick();
        check("R12 sticky", 64'(overflow), 1);
    endtask

    task automatic t_halt();
        restart(3'd1, 1'b1);
        check("R11 restart clears overflow", 64'(overflow), 0);
        for (int i = 0; i < 3; i++) put_data(24'(i), 1'b0);
        cpu_halt = 1'b1;
        put_data(24'h000777, 1'b0);
        check("R11 halted no write", 64'(ram_we), 0);
        check("R11 pointer kept",    64'(wr_ptr), 3);
        cpu_halt = 1'b0;
        tick();
        put_data(24'h000888, 1'b0);
        check("R11 resume slot", 64'(ram_addr), 1011);
        trc_en = 1'b0;
        put_data(24'h000999, 1'b0);
        check("R11 disabled no write", 64'(ram_we), 0);
        restart(3'd1, 1'b1);
        check("R11 pointer cleared", 64'(wr_ptr), 0);
        put_data(24'h000AAA, 1'b0);
        check("R11 restart address", 64'(ram_addr), 1008);
    endtask

    task automatic t_size_off();
        restart(3'd0, 1'b1);
        put_data(24'h000001, 1'b0);
        check("R10 size 0 no write", 64'(ram_we), 0);
        restart(3'd5, 1'b1);
        put_data(24'h000002, 1'b0);
        check("R10 size 5 no write", 64'(ram_we), 0);
        check("R10 not stopped",     64'(stopped), 0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; trc_en = 1'b0; cpu_halt = 1'b0; cont_mode = 1'b0;
        size_sel = 3'd0; br_valid = 1'b0; br_target = '0; da_valid = 1'b0;
        da_write = 1'b0; da_addr = '0; ev_in = '0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_sizes();
        t_single();
        t_cont();
        t_prio();
        t_ts();
        t_branch();
        t_ovf();
        t_halt();
        t_size_off();
        summary();
        $finish;
    end

endmodule